// File: doc/BRIEF.md
# Two-Branch Completion Join

This block merges the completion reports of two concurrently running branches into one completion report for both together. Each branch reports that it is done with a single-cycle pulse. The block produces a single-cycle join pulse once both branches have reported. The two reports may arrive in the same cycle, or one after the other with any number of cycles between them.

Inside the block, a control token circulates forever through a short loop. It first waits until either branch reports. If both report in that same cycle, it fires at once. If only one reports, the token moves on and, from the next cycle onward, waits for the other branch. It fires in the cycle the other report arrives. Every fire is followed by one dead cycle, and then the loop starts again.

The join pulse is produced combinationally from the branch inputs, so it appears in the same cycle as the completion that closes the join. Each branch is assumed to pulse exactly once per join.

Top module: `join_sync`

## Requirements
- R1: While `rst_ni` is low, and for the first `RST_SYNC_STAGES`+1 rising clock edges after `rst_ni` rises, `joined_o` stays low and branch inputs are ignored. From then on, the loop waits for a first completion.
- R2: When the loop is waiting for a first completion and `done_a_i` and `done_b_i` are both high in one cycle, `joined_o` is high in that same cycle.
- R3: When the loop is waiting for a first completion and exactly one of the two inputs is high, `joined_o` stays low in that cycle.
- R4: After a lone first completion, `joined_o` goes high in the first later cycle in which either input is high. The gap may be one cycle or a thousand.
- R5: The order in which the branches complete has no effect: a-then-b and b-then-a give the same join timing.
- R6: The cycle after a join pulse is dead. `joined_o` is low in that cycle, and any input pulse in that cycle is discarded. The loop waits for a first completion again from the cycle after that.
- R7: `joined_o` is never high in two consecutive cycles.
- R8: `joined_o` is high only in a cycle where at least one of `done_a_i` and `done_b_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| done_a_i | input | 1 | Single-cycle completion pulse of branch A |
| done_b_i | input | 1 | Single-cycle completion pulse of branch B |
| joined_o | output | 1 | Single-cycle pulse when both branches have completed |

## Verification
The join is exercised with four kinds of pattern:
- **Simultaneous completion** confirms the same-cycle fire path.
- **A before B and B before A, with short gaps** (including back-to-back cycles) show that order has no effect and that the second wait is live from the very next cycle.
- **A thousand-cycle gap** shows that the armed state holds without a timeout.
- **Completions that fall into the dead cycle after a join** show that they are discarded rather than counted toward the next join.

A seeded random mix of gaps, orders and idle spacings is compared cycle by cycle with an expected pulse. The bench computes that pulse from the three-phase behaviour stated in the requirements.

// File: rtl/join_sync_pkg.sv
package join_sync_pkg;

  // Position of the circulating control token.
  typedef enum logic [1:0] {
    TOK_BOOT   = 2'd0,  // held in reset, enters loop on first free edge
    TOK_FIRST  = 2'd1,  // waiting for either branch
    TOK_SECOND = 2'd2,  // one branch seen, waiting for the other
    TOK_REST   = 2'd3   // dead cycle after a join
  } tok_e;

endpackage

// File: rtl/join_sync_rst.sv
module join_sync_rst #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= '0;
        else          chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= '0;
        else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_no = chain_q[STAGES-1];

endmodule

// File: rtl/join_sync_seq.sv
module join_sync_seq
  import join_sync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic fire_o
);

  tok_e state_q;
  tok_e state_d;
  logic step_en;

  // Next-state and output decode
  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    case (state_q)
      TOK_BOOT: state_d = TOK_FIRST;
      TOK_FIRST: begin
        if (a_i && b_i) begin
          fire_o  = 1'b1;
          state_d = TOK_REST;
        end else if (a_i || b_i) begin
          state_d = TOK_SECOND;
        end
      end
      TOK_SECOND: begin
        if (a_i || b_i) begin
          fire_o  = 1'b1;
          state_d = TOK_REST;
        end
      end
      TOK_REST: state_d = TOK_FIRST;
      default:  state_d = TOK_FIRST;
    endcase
  end

  assign step_en = (state_d != state_q);

  // Token register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= TOK_BOOT;
    else if (step_en) state_q <= state_d;
  end

endmodule

// File: rtl/join_sync.sv
module join_sync #(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_a_i,
  input  logic done_b_i,
  output logic joined_o
);

  logic rst_int_n;

  join_sync_rst #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_int_n)
  );

  join_sync_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .a_i    (done_a_i),
    .b_i    (done_b_i),
    .fire_o (joined_o)
  );

endmodule

// File: rtl/join_sync_chk.sv
module join_sync_chk
  import join_sync_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic a_i,
  input logic b_i,
  input logic fire_o,
  input tok_e state_q
);

  // R2: both at once while waiting first -> fire now
  a_r2_both_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TOK_FIRST && a_i && b_i) |-> fire_o);

  // R3: lone first completion arms the second wait without firing
  a_r3_lone_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TOK_FIRST && (a_i ^ b_i)) |=> (state_q == TOK_SECOND && !$past(fire_o)));

  // R4: armed wait stays armed until an input arrives
  a_r4_hold_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TOK_SECOND && !a_i && !b_i) |=> state_q == TOK_SECOND);

  // R6: dead cycle follows every fire
  a_r6_rest_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (state_q == TOK_REST));

  // R7: no back-to-back pulses
  a_r7_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  // R8: a pulse needs an input in the same cycle
  a_r8_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (a_i || b_i));

  // R1: no pulse outside the two wait positions
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TOK_BOOT || state_q == TOK_REST) |-> !fire_o);

endmodule

bind join_sync_seq join_sync_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .b_i     (b_i),
  .fire_o  (fire_o),
  .state_q (state_q)
);

// File: tb/join_sync_test.sv
module join_sync_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic fa, fb;
  logic joined;

  int n_cmp = 0;
  int n_bad = 0;
  int phase = 0;  // 0 wait-first, 1 wait-second, 2 dead

  always #(CLK_PERIOD/2) clk = ~clk;

  join_sync uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .done_a_i (fa),
    .done_b_i (fb),
    .joined_o (joined)
  );

  function automatic logic exp_pulse(int ph, logic a, logic b);
    if (ph == 0) return a & b;
    if (ph == 1) return a | b;
    return 1'b0;
  endfunction

  function automatic int next_phase(int ph, logic a, logic b);
    if (ph == 0) return (a & b) ? 2 : ((a | b) ? 1 : 0);
    if (ph == 1) return (a | b) ? 2 : 1;
    return 0;
  endfunction

  task automatic check(logic exp, string req);
    n_cmp++;
    if (joined !== exp) begin
      n_bad++;
      $display("FAIL %s: joined_o=%b expected %b at %0t", req, joined, exp, $time);
    end
  endtask

  // One cycle: drive inputs after falling edge, check before next rising edge
  task automatic step(logic a, logic b, string req);
    logic e;
    @(negedge clk);
    fa = a;
    fb = b;
    #1;
    e = exp_pulse(phase, a, b);
    check(e, req);
    phase = next_phase(phase, a, b);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd91357);
    rst_n = 1'b0;
    fa = 1'b1;
    fb = 1'b1;
    // R1: reset holds output low even with both inputs high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(1'b0, "R1 reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    fa = 1'b0;
    fb = 1'b0;
    #1;
    check(1'b0, "R1 release");
    // R1: boot cycles, inputs ignored (model stays quiet)
    phase = 2;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      fa = 1'b1;
      fb = 1'b1;
      #1;
      check(1'b0, "R1 boot");
    end
    @(negedge clk);
    fa = 1'b0;
    fb = 1'b0;
    #1;
    check(1'b0, "R1 boot");
    phase = 0;
    idle(2, "R1 idle");

    // R2: simultaneous completion
    step(1'b1, 1'b1, "R2 same cycle");
    idle(3, "R6 dead");

    // R3/R4/R5: A then B with one-cycle gap, B then A with gap 5
    step(1'b1, 1'b0, "R3 lone a");
    step(1'b0, 1'b1, "R4 b next cycle");
    idle(2, "R6 dead");
    step(1'b0, 1'b1, "R5 lone b");
    idle(5, "R4 gap");
    step(1'b1, 1'b0, "R5 a after b");
    idle(2, "R6 dead");

    // R4: very large gap
    step(1'b1, 1'b0, "R3 lone a");
    idle(1000, "R4 long gap");
    step(1'b0, 1'b1, "R4 after long gap");

    // R6: pulses in the dead cycle are discarded
    step(1'b1, 1'b0, "R6 dead a dropped");
    step(1'b0, 1'b1, "R6 b lone after dead");
    step(1'b1, 1'b0, "R6 a closes join");
    step(1'b1, 1'b1, "R6 both in dead cycle");
    idle(2, "R6 quiet");

    // Random episodes
    for (int ep = 0; ep < 120; ep++) begin
      int gap;
      bit afirst;
      gap = int'($urandom_range(0, 40));
      afirst = bit'($urandom_range(0, 1));
      if (gap == 0) begin
        step(1'b1, 1'b1, "R2 random");
      end else begin
        step(afirst, !afirst, "R3 random");
        idle(gap - 1, "R4 random");
        step(!afirst, afirst, "R5 random");
      end
      idle(1 + int'($urandom_range(0, 3)), "R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule